// File: doc/BRIEF.md
# Serial Game Controller Port

This block puts two game-controller ports on a CPU bus. Each port keeps an 8-bit snapshot of one controller's buttons and hands it to the CPU one bit per read. A single strobe register decides when the snapshots are taken. That register sits behind a write to the first port's address and is shared by both ports.

While the strobe is held at 1, each port follows the live buttons. A read then always reports the first button. When software clears the strobe, both ports freeze the buttons of that cycle. Reads then walk through the eight buttons, least significant first. Once the eighth button has gone out, every further read reports 1.

Each returned byte carries a constant 1 in bit 6 and the serial bit in bit 0. A peek strobe returns the same byte as a read without advancing the port, so a debugger can look at a port without disturbing it. Read data is registered and appears in the cycle after the access.

Top module: `serial_pad_ports`

## Requirements
- R1: Port 0 answers reads at address 0x4016 and port 1 answers reads at address 0x4017. Only a write to 0x4016 reaches the strobe. Writes to 0x4017 or to any other address, and reads at any other address, change no port state.
- R2: A strobe write stores data bit 0 only. Bits 7..1 of the written byte have no effect.
- R3: While the strobe is 1, a read of a port returns that port's live button bit 0. Repeated reads keep returning it.
- R4: A write that takes the strobe from 1 to 0 freezes both ports with the button vectors present in that cycle. Later changes on the button inputs do not alter the frozen bits.
- R5: The read byte is 0x40 with bit 0 replaced by the port's current serial bit, and all other bits are 0. It is registered: it appears in the cycle after the access and holds until the next access to the same port.
- R6: After eight reads following a freeze, every further read of that port returns 0x41 until the next freeze.
- R7: A peek (cpu_peek high, cpu_rd low) at a port address returns the same byte a read would, and does not advance that port.
- R8: After reset the strobe is 0, both ports hold all ones, and both read-data outputs are 0x00.
- R9: When a read and a strobe-clearing write hit 0x4016 in the same cycle, the read sees the strobe value from before the write. Port 0 is left holding the fresh freeze, not a shifted copy of it.
- R10: Serial order from the first read is: primary button (bit 0), secondary button, select, start, up, down, left, right (bit 7). Buttons are active high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe; advances the addressed port |
| cpu_wr | input | 1 | Write strobe |
| cpu_peek | input | 1 | Side-effect-free read strobe |
| btn0 | input | 8 | Live buttons of controller 0 |
| btn1 | input | 8 | Live buttons of controller 1 |
| rdata0 | output | 8 | Registered read byte of port 0 |
| rdata1 | output | 8 | Registered read byte of port 1 |

## Verification
A read and a strobe write can reach port 0 in the same cycle, because both use address 0x4016. The bench raises the strobe first. It then issues one access with cpu_rd and cpu_wr both high and write data 0. The buttons are chosen so that live bit 0 differs from bit 1. The returned byte must be the live bit 0. The next two reads must yield bits 0 and 1 of the frozen vector, even after the live buttons are changed. A design that let the shift overwrite the freeze would return bit 1 first.

// File: rtl/pad_pkg.sv
package pad_pkg;
  localparam int PAD_DATA_W    = 8;
  localparam int PAD_FIXED_POS = 6;

  typedef logic [PAD_DATA_W-1:0] pad_byte_t;

  function automatic pad_byte_t pad_rd_byte(input logic ser_bit);
    pad_byte_t b;
    b                = '0;
    b[PAD_FIXED_POS] = 1'b1;
    b[0]             = ser_bit;
    return b;
  endfunction
endpackage

// File: rtl/pad_strobe_ctrl.sv
module pad_strobe_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic strobe_q,
  output logic fall_p
);
  // Falling transition is seen in the write cycle itself so the freeze
  // lands on the same edge that clears the strobe.
  assign fall_p = wr_hit && strobe_q && !wr_bit;

  always_ff @(posedge clk) begin
    if (rst)         strobe_q <= 1'b0;
    else if (wr_hit) strobe_q <= wr_bit;
  end
endmodule

// File: rtl/pad_shift_latch.sv
module pad_shift_latch #(
  parameter int NUM_BTN = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strobe,
  input  logic               capture,
  input  logic               shift,
  input  logic [NUM_BTN-1:0] btn,
  output logic               ser_bit
);
  logic [NUM_BTN-1:0] sh_q;
  logic [NUM_BTN-1:0] src;

  // Strobe high: the port behaves as if reloaded from the live buttons.
  assign src     = strobe ? btn : sh_q;
  assign ser_bit = src[0];

  always_ff @(posedge clk) begin
    if (rst)          sh_q <= '1;
    else if (capture) sh_q <= btn;
    else if (shift)   sh_q <= {1'b1, src[NUM_BTN-1:1]};
  end
endmodule

// File: rtl/serial_pad_ports.sv
module serial_pad_ports
  import pad_pkg::*;
#(
  parameter int                 ADDR_W     = 16,
  parameter int                 NUM_BTN    = 8,
  parameter logic [ADDR_W-1:0]  PORT0_ADDR = 16'h4016,
  parameter logic [ADDR_W-1:0]  PORT1_ADDR = 16'h4017
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [PAD_DATA_W-1:0] cpu_wdata,
  input  logic                  cpu_rd,
  input  logic                  cpu_wr,
  input  logic                  cpu_peek,
  input  logic [NUM_BTN-1:0]    btn0,
  input  logic [NUM_BTN-1:0]    btn1,
  output logic [PAD_DATA_W-1:0] rdata0,
  output logic [PAD_DATA_W-1:0] rdata1
);
  localparam int NUM_PORTS = 2;

  logic              strobe_q;
  logic              fall_p;
  logic              unused_wdata_hi;
  logic [NUM_BTN-1:0] btn_v  [NUM_PORTS];
  pad_byte_t          rd_v   [NUM_PORTS];
  logic [NUM_PORTS-1:0] hit;

  assign unused_wdata_hi = ^cpu_wdata[PAD_DATA_W-1:1];

  assign btn_v[0] = btn0;
  assign btn_v[1] = btn1;
  assign hit[0]   = (cpu_addr == PORT0_ADDR);
  assign hit[1]   = (cpu_addr == PORT1_ADDR);

  pad_strobe_ctrl u_strobe (
    .clk      (clk),
    .rst      (rst),
    .wr_hit   (cpu_wr && hit[0]),
    .wr_bit   (cpu_wdata[0]),
    .strobe_q (strobe_q),
    .fall_p   (fall_p)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic ser;
    pad_shift_latch #(.NUM_BTN(NUM_BTN)) u_latch (
      .clk     (clk),
      .rst     (rst),
      .strobe  (strobe_q),
      .capture (fall_p),
      .shift   (cpu_rd && hit[p]),
      .btn     (btn_v[p]),
      .ser_bit (ser)
    );
    always_ff @(posedge clk) begin
      if (rst)                              rd_v[p] <= '0;
      else if ((cpu_rd || cpu_peek) && hit[p]) rd_v[p] <= pad_rd_byte(ser);
    end
  end

  assign rdata0 = rd_v[0];
  assign rdata1 = rd_v[1];
endmodule

// File: rtl/pad_ports_chk.sv
module pad_ports_chk #(
  parameter int                ADDR_W     = 16,
  parameter int                NUM_BTN    = 8,
  parameter logic [ADDR_W-1:0] PORT0_ADDR = 16'h4016,
  parameter logic [ADDR_W-1:0] PORT1_ADDR = 16'h4017
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  cpu_addr,
  input logic               cpu_rd,
  input logic               cpu_peek,
  input logic [NUM_BTN-1:0] btn0,
  input logic [NUM_BTN-1:0] btn1,
  input logic               strobe_q,
  input logic [7:0]         rdata0,
  input logic [7:0]         rdata1
);
  logic acc0, acc1;
  assign acc0 = (cpu_rd || cpu_peek) && cpu_addr == PORT0_ADDR;
  assign acc1 = (cpu_rd || cpu_peek) && cpu_addr == PORT1_ADDR;

  p_fixed_bits_r5: assert property (@(posedge clk) disable iff (rst)
    acc0 |=> rdata0[7:1] == 7'b0100000);

  p_hold0_r5: assert property (@(posedge clk) disable iff (rst)
    !acc0 |=> $stable(rdata0));

  p_hold1_r5: assert property (@(posedge clk) disable iff (rst)
    !acc1 |=> $stable(rdata1));

  p_live0_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe_q && acc0) |=> rdata0[0] == $past(btn0[0]));

  p_live1_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe_q && acc1) |=> rdata1[0] == $past(btn1[0]));
endmodule

bind serial_pad_ports pad_ports_chk #(
  .ADDR_W(ADDR_W), .NUM_BTN(NUM_BTN),
  .PORT0_ADDR(PORT0_ADDR), .PORT1_ADDR(PORT1_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
  .cpu_peek(cpu_peek), .btn0(btn0), .btn1(btn1), .strobe_q(strobe_q),
  .rdata0(rdata0), .rdata1(rdata1)
);

// File: tb/test_serial_pad_ports.sv
`timescale 1ns/1ps
module test_serial_pad_ports;
  logic        clk = 0;
  logic        rst = 1;
  logic [15:0] cpu_addr = 16'h0;
  logic [7:0]  cpu_wdata = 8'h0;
  logic        cpu_rd = 0, cpu_wr = 0, cpu_peek = 0;
  logic [7:0]  btn0 = 8'hA5, btn1 = 8'h3C;
  logic [7:0]  rdata0, rdata1;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  serial_pad_ports i_serial_pad_ports (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_peek(cpu_peek),
    .btn0(btn0), .btn1(btn1), .rdata0(rdata0), .rdata1(rdata1)
  );

  // {op, sel, wdata, exp0, exp1}: op 0=write 1=read 2=peek; sel 0=4016 1=4017 2=4000
  localparam int NV = 29;
  localparam logic [31:0] VEC [NV] = '{
    {4'd0,4'd0,8'h01,8'h41,8'h41}, // R2 set strobe
    {4'd1,4'd0,8'h00,8'h41,8'h41}, // R3
    {4'd1,4'd0,8'h00,8'h41,8'h41}, // R3
    {4'd1,4'd1,8'h00,8'h41,8'h40}, // R3 port1 live
    {4'd0,4'd0,8'h00,8'h41,8'h40}, // R4 freeze
    {4'd1,4'd0,8'h00,8'h41,8'h40}, // R10 primary
    {4'd1,4'd0,8'h00,8'h40,8'h40}, // R10 secondary
    {4'd1,4'd0,8'h00,8'h41,8'h40}, // R10 select
    {4'd1,4'd0,8'h00,8'h40,8'h40}, // R10 start
    {4'd1,4'd0,8'h00,8'h40,8'h40}, // R10 up
    {4'd1,4'd0,8'h00,8'h41,8'h40}, // R10 down
    {4'd1,4'd0,8'h00,8'h40,8'h40}, // R10 left
    {4'd1,4'd0,8'h00,8'h41,8'h40}, // R10 right
    {4'd1,4'd0,8'h00,8'h41,8'h40}, // R6
    {4'd1,4'd1,8'h00,8'h41,8'h40}, // R4 port1 bit0
    {4'd2,4'd1,8'h00,8'h41,8'h40}, // R7 peek bit1
    {4'd1,4'd1,8'h00,8'h41,8'h40}, // R7 bit1 again
    {4'd1,4'd1,8'h00,8'h41,8'h41}, // R5 bit2
    {4'd0,4'd0,8'hFE,8'h41,8'h41}, // R2 upper bits
    {4'd1,4'd1,8'h00,8'h41,8'h41}, // R2 bit3
    {4'd0,4'd1,8'h01,8'h41,8'h41}, // R1 write 4017
    {4'd1,4'd1,8'h00,8'h41,8'h41}, // R1 bit4
    {4'd0,4'd2,8'h01,8'h41,8'h41}, // R1 write other
    {4'd1,4'd1,8'h00,8'h41,8'h41}, // R1 bit5
    {4'd1,4'd2,8'h00,8'h41,8'h41}, // R1 read other
    {4'd1,4'd1,8'h00,8'h41,8'h40}, // R1 bit6
    {4'd1,4'd1,8'h00,8'h41,8'h40}, // R10 bit7
    {4'd1,4'd1,8'h00,8'h41,8'h41}, // R6 port1
    {4'd2,4'd0,8'h00,8'h41,8'h41}  // R7 peek port0
  };

  function automatic logic [15:0] sel_addr(input logic [3:0] s);
    case (s)
      4'd0:    return 16'h4016;
      4'd1:    return 16'h4017;
      default: return 16'h4000;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic access(input logic [3:0] op, input logic [3:0] sel, input logic [7:0] wd);
    cpu_addr  = sel_addr(sel);
    cpu_wdata = wd;
    cpu_wr    = (op == 4'd0);
    cpu_rd    = (op == 4'd1);
    cpu_peek  = (op == 4'd2);
    @(negedge clk);
    cpu_wr = 0; cpu_rd = 0; cpu_peek = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R8 rdata0 reset", rdata0, 8'h00);
    check("R8 rdata1 reset", rdata1, 8'h00);
    access(4'd1, 4'd0, 8'h00);
    check("R8 port0 ones", rdata0, 8'h41);
    access(4'd1, 4'd1, 8'h00);
    check("R8 port1 ones", rdata1, 8'h41);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][31:28], VEC[i][27:24], VEC[i][23:16]);
      check($sformatf("vec%0d R1..R10 port0", i), rdata0, VEC[i][15:8]);
      check($sformatf("vec%0d R1..R10 port1", i), rdata1, VEC[i][7:0]);
    end

    // R9: read and strobe-clearing write at 0x4016 together
    btn0 = 8'h02;
    access(4'd0, 4'd0, 8'h01);
    cpu_addr = 16'h4016; cpu_wdata = 8'h00; cpu_wr = 1; cpu_rd = 1;
    @(negedge clk);
    cpu_wr = 0; cpu_rd = 0;
    check("R9 read sees old strobe", rdata0, 8'h40);
    btn0 = 8'hFF;
    access(4'd1, 4'd0, 8'h00);
    check("R9 frozen bit0", rdata0, 8'h40);
    access(4'd1, 4'd0, 8'h00);
    check("R4 frozen bit1", rdata0, 8'h41);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule